// File: doc/BRIEF.md
# ADC Conversion Sequencer with Sleep Handling

This block controls a 10-bit successive-approximation converter. Software writes a control word that holds an enable bit, a start bit, a channel index, a conversion-clock choice, a result-layout choice and a reference choice. When a start is accepted, the block selects the analog channel and runs one setup step followed by one comparator-guided bit decision per step, MSB first. It drives a trial code to the DAC and reads a one-bit comparator answer. On completion it loads a high/low byte pair of result registers, drops its busy flag and sets a sticky completion flag.

The conversion clock is either the system clock divided by 2, 8 or 32, or a tick from an internal RC oscillator. The choice decides what happens at sleep entry. A non-RC conversion is abandoned and the converter is powered down. An RC conversion is held back until one instruction boundary has passed after the start, and then runs through sleep. At the end it either requests a wake-up or powers the converter down, depending on the interrupt enable. The enable bit itself is never changed by sleep. Instruction boundaries, sleep entry and RC ticks arrive as one-cycle strobes.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, adon_o, busy_o, flag_o, pwr_o and wake_o are 0, chan_sel_o is all zeros and trial_o is 0.
- R2: A write accepted while idle loads every control field. chan_sel_o is one-hot with bit wr_chan_i set while the enable is 1, and all zeros while it is 0. vref_o follows the reference field. pwr_o equals the enable after any accepted write.
- R3: A write with wr_go_i=1 and wr_adon_i=1 while idle starts a conversion, and busy_o rises after that edge. With wr_adon_i=0 the start is ignored and busy_o stays 0.
- R4: After the setup step trial_o is 10'h200. Each later step keeps the trial bit when cmp_i=1 (input at or above the trial level) and sets the next lower bit. The final result is the largest code whose trial reported at-or-above.
- R5: On the edge that takes the last step, busy_o falls, the result registers load and flag_o is set.
- R6: With wr_right_i=0, res_hi_o = result[9:2] and res_lo_o = {result[1:0],6'b0}. With wr_right_i=1, res_hi_o = {6'b0,result[9:8]} and res_lo_o = result[7:0].
- R7: wr_clk_i[1:0] = 00, 01 or 10 gives one step every 2, 8 or 32 system clocks (wr_clk_i[2] is ignored). busy_o stays high for exactly 11 times the divisor clocks after the starting edge.
- R8: wr_clk_i[1:0] = 11 selects RC ticks (rc_tick_i) as steps. After a start the setup step does not begin until an instr_stb_i pulse: RC ticks before it leave trial_o at 0. The conversion then takes exactly 11 ticks.
- R9: A sleep_i pulse during a non-RC conversion aborts it. On the next edge busy_o and pwr_o are 0, flag_o is not set, adon_o stays 1 and the result registers keep their values.
- R10: An RC conversion continues through sleep. At completion while asleep with ie_i=1, wake_o pulses for one cycle. With ie_i=0, pwr_o drops while adon_o stays 1.
- R11: A write while a conversion is pending or running is ignored in all fields. chan_sel_o holds and a second start has no effect on the conversion length.
- R12: flag_o stays set until a flag_clr_i pulse clears it.
- R13: Reset during a conversion aborts it and returns the control fields to their reset values. The result registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Control-word write strobe |
| wr_adon_i | input | 1 | Converter enable field |
| wr_go_i | input | 1 | Start field |
| wr_chan_i | input | 3 | Channel index field |
| wr_clk_i | input | 3 | Conversion clock select field |
| wr_right_i | input | 1 | Result layout field (1 = right) |
| wr_vref_i | input | 1 | Reference select field |
| ie_i | input | 1 | Converter interrupt enable |
| flag_clr_i | input | 1 | Clears the completion flag |
| instr_stb_i | input | 1 | Instruction boundary strobe |
| sleep_i | input | 1 | Sleep entry strobe |
| rc_tick_i | input | 1 | Internal RC oscillator tick |
| cmp_i | input | 1 | Comparator: input at or above trial |
| trial_o | output | 10 | Trial code to the DAC |
| chan_sel_o | output | 8 | One-hot analog mux select |
| vref_o | output | 1 | Reference select |
| pwr_o | output | 1 | Converter power |
| adon_o | output | 1 | Enable bit readback |
| busy_o | output | 1 | Start/busy readback |
| flag_o | output | 1 | Sticky completion flag |
| wake_o | output | 1 | Wake request pulse |
| res_hi_o | output | 8 | High result register |
| res_lo_o | output | 8 | Low result register |

## Verification
The assertions assume one-cycle strobes on sleep_i, instr_stb_i and rc_tick_i. They also assume a combinational comparator answer that depends only on the current trial code, and a sleep strobe that does not coincide with an accepted write. The bench models the comparator as a fixed input level compared against trial_o. It raises each strobe for exactly one clock. It issues sleep only while no write is in flight, and it ends sleep with an instruction strobe before the next scenario.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_BITS} sar_phase_e;

  localparam logic [1:0] CK_DIV_A = 2'b00;
  localparam logic [1:0] CK_DIV_B = 2'b01;
  localparam logic [1:0] CK_DIV_C = 2'b10;
  localparam logic [1:0] CK_RC    = 2'b11;

  function automatic logic is_rc(input logic [2:0] sel);
    return sel[1:0] == CK_RC;
  endfunction
endpackage

// File: rtl/adc_step_gen.sv
module adc_step_gen
  import adc_seq_pkg::*;
#(
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  input  logic       rc_tick_i,
  output logic       step_o
);
  localparam int CNT_W = $clog2(DIV_C);

  logic [CNT_W-1:0] cnt_q, lim;
  logic rc_sel, hit;

  always_comb begin
    case (sel_i)
      CK_DIV_A: lim = CNT_W'(DIV_A - 1);
      CK_DIV_B: lim = CNT_W'(DIV_B - 1);
      default:  lim = CNT_W'(DIV_C - 1);
    endcase
  end

  assign rc_sel = (sel_i == CK_RC);
  assign hit    = (cnt_q == lim);
  assign step_o = run_i & (rc_sel ? rc_tick_i : hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!run_i || hit || rc_sel) cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  // divided steps never come back to back (divisors >= 2)
  p_step_gap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !rc_sel) |=> !step_o);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic             step_i,
  input  logic             cmp_i,
  output logic             active_o,
  output logic             done_o,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o
);
  localparam int IDX_W = $clog2(RES_W);
  localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(RES_W - 1);

  sar_phase_e       phase_q;
  logic [RES_W-1:0] sar_q;
  logic [IDX_W-1:0] idx_q;

  assign active_o = (phase_q != PH_IDLE);
  assign trial_o  = sar_q;
  assign done_o   = (phase_q == PH_BITS) && step_i && (idx_q == '0) && !abort_i;

  always_comb begin
    result_o        = sar_q;
    result_o[idx_q] = cmp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      sar_q   <= '0;
      idx_q   <= '0;
    end else if (abort_i) begin
      phase_q <= PH_IDLE;
      sar_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SETUP;
          sar_q   <= '0;
        end
        PH_SETUP: if (step_i) begin
          sar_q   <= MSB_ONE;
          idx_q   <= TOP_IDX;
          phase_q <= PH_BITS;
        end
        PH_BITS: if (step_i) begin
          if (idx_q == '0) begin
            sar_q   <= '0;
            phase_q <= PH_IDLE;
          end else begin
            sar_q[idx_q]        <= cmp_i;
            sar_q[idx_q - 1'b1] <= 1'b1;
            idx_q               <= idx_q - 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !active_o);
  p_first_trial_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_SETUP && step_i && !abort_i) |=> (trial_o == MSB_ONE));
endmodule

// File: rtl/adc_res_fmt.sv
module adc_res_fmt #(
  parameter int RES_W = 10
) (
  input  logic [RES_W-1:0] res_i,
  input  logic             right_i,
  output logic [7:0]       hi_o,
  output logic [7:0]       lo_o
);
  localparam int LO_N = RES_W - 8;

  always_comb begin
    if (right_i) begin
      hi_o = {{(8-LO_N){1'b0}}, res_i[RES_W-1:8]};
      lo_o = res_i[7:0];
    end else begin
      hi_o = res_i[RES_W-1 -: 8];
      lo_o = {res_i[LO_N-1:0], {(8-LO_N){1'b0}}};
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int CH_W  = 3,
  parameter int DIV_A = 2,
  parameter int DIV_B = 8,
  parameter int DIV_C = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_i,
  input  logic                   wr_adon_i,
  input  logic                   wr_go_i,
  input  logic [CH_W-1:0]        wr_chan_i,
  input  logic [2:0]             wr_clk_i,
  input  logic                   wr_right_i,
  input  logic                   wr_vref_i,
  input  logic                   ie_i,
  input  logic                   flag_clr_i,
  input  logic                   instr_stb_i,
  input  logic                   sleep_i,
  input  logic                   rc_tick_i,
  input  logic                   cmp_i,
  output logic [RES_W-1:0]       trial_o,
  output logic [(1<<CH_W)-1:0]   chan_sel_o,
  output logic                   vref_o,
  output logic                   pwr_o,
  output logic                   adon_o,
  output logic                   busy_o,
  output logic                   flag_o,
  output logic                   wake_o,
  output logic [7:0]             res_hi_o,
  output logic [7:0]             res_lo_o
);
  localparam int N_CH = 1 << CH_W;

  logic            adon_q, right_q, vref_q, hold_q, asleep_q, pwr_off_q, flag_q, wake_q;
  logic [CH_W-1:0] chan_q;
  logic [2:0]      clk_q;
  logic [7:0]      res_hi_q, res_lo_q, fmt_hi, fmt_lo;
  logic [RES_W-1:0] sar_res;
  logic busy, wr_ok, rc_cur, rc_new, start_req, sar_start, sar_abort;
  logic sar_active, sar_done, step;

  assign busy      = hold_q | sar_active;
  assign wr_ok     = wr_i & ~busy;
  assign rc_cur    = is_rc(clk_q);
  assign rc_new    = is_rc(wr_clk_i);
  assign start_req = wr_ok & wr_go_i & wr_adon_i;
  assign sar_abort = sleep_i & ~rc_cur;
  assign sar_start = (start_req & ~rc_new) | (hold_q & instr_stb_i);

  adc_step_gen #(.DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)) u_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (sar_active),
    .sel_i     (clk_q[1:0]),
    .rc_tick_i (rc_tick_i),
    .step_o    (step)
  );

  adc_sar_core #(.RES_W(RES_W)) u_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (sar_start),
    .abort_i  (sar_abort),
    .step_i   (step),
    .cmp_i    (cmp_i),
    .active_o (sar_active),
    .done_o   (sar_done),
    .trial_o  (trial_o),
    .result_o (sar_res)
  );

  adc_res_fmt #(.RES_W(RES_W)) u_fmt (
    .res_i   (sar_res),
    .right_i (right_q),
    .hi_o    (fmt_hi),
    .lo_o    (fmt_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adon_q  <= 1'b0;
      chan_q  <= '0;
      clk_q   <= '0;
      right_q <= 1'b0;
      vref_q  <= 1'b0;
    end else if (wr_ok) begin
      adon_q  <= wr_adon_i;
      chan_q  <= wr_chan_i;
      clk_q   <= wr_clk_i;
      right_q <= wr_right_i;
      vref_q  <= wr_vref_i;
    end
  end

  // RC start waits for one instruction boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  hold_q <= 1'b0;
    else if (sar_abort)           hold_q <= 1'b0;
    else if (start_req && rc_new) hold_q <= 1'b1;
    else if (instr_stb_i)         hold_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asleep_q  <= 1'b0;
      wake_q    <= 1'b0;
      pwr_off_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      if (sleep_i)                            asleep_q <= 1'b1;
      else if (instr_stb_i || (sar_done && ie_i)) asleep_q <= 1'b0;

      wake_q <= sar_done & asleep_q & ie_i;

      if (sar_abort)                          pwr_off_q <= 1'b1;
      else if (sar_done && asleep_q && !ie_i) pwr_off_q <= 1'b1;
      else if (wr_ok)                         pwr_off_q <= 1'b0;

      if (sar_done)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  // result pair is outside the reset domain on purpose
  always_ff @(posedge clk_i) begin
    if (sar_done) begin
      res_hi_q <= fmt_hi;
      res_lo_q <= fmt_lo;
    end
  end

  assign chan_sel_o = adon_q ? (N_CH'(1) << chan_q) : '0;
  assign vref_o     = vref_q;
  assign pwr_o      = adon_q & ~pwr_off_q;
  assign adon_o     = adon_q;
  assign busy_o     = busy;
  assign flag_o     = flag_q;
  assign wake_o     = wake_q;
  assign res_hi_o   = res_hi_q;
  assign res_lo_o   = res_lo_q;

  p_go_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o && !wr_adon_i) |=> !busy_o);
  p_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sar_done |=> (!busy_o && flag_o));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_q |-> !sar_active);
  p_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && busy_o && !rc_cur) |=> (!busy_o && !pwr_o && adon_o));
  p_wake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> flag_o);
  p_sleep_adon_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_i && !wr_i) |=> $stable(adon_o));
  p_chan_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && busy_o) |=> $stable(chan_sel_o));
endmodule

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 0, wr_adon_i = 0, wr_go_i = 0, wr_right_i = 0, wr_vref_i = 0;
  logic [2:0] wr_chan_i = '0, wr_clk_i = '0;
  logic       ie_i = 0, flag_clr_i = 0, instr_stb_i = 0, sleep_i = 0, rc_tick_i = 0;
  logic       cmp_i;
  logic [9:0] trial_o;
  logic [7:0] chan_sel_o, res_hi_o, res_lo_o;
  logic       vref_o, pwr_o, adon_o, busy_o, flag_o, wake_o;
  logic [9:0] vin = '0;
  int n_chk = 0, n_err = 0;
  bit fin = 0;

  always #2.5 clk = ~clk;
  assign cmp_i = (vin >= trial_o);

  adc_seq_ctrl u_adc_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr_i), .wr_adon_i(wr_adon_i), .wr_go_i(wr_go_i),
    .wr_chan_i(wr_chan_i), .wr_clk_i(wr_clk_i), .wr_right_i(wr_right_i), .wr_vref_i(wr_vref_i),
    .ie_i(ie_i), .flag_clr_i(flag_clr_i), .instr_stb_i(instr_stb_i), .sleep_i(sleep_i),
    .rc_tick_i(rc_tick_i), .cmp_i(cmp_i), .trial_o(trial_o), .chan_sel_o(chan_sel_o),
    .vref_o(vref_o), .pwr_o(pwr_o), .adon_o(adon_o), .busy_o(busy_o), .flag_o(flag_o),
    .wake_o(wake_o), .res_hi_o(res_hi_o), .res_lo_o(res_lo_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic adon, input logic go, input logic [2:0] ch,
                       input logic [2:0] ck, input logic right, input logic vref);
    wr_i = 1; wr_adon_i = adon; wr_go_i = go; wr_chan_i = ch;
    wr_clk_i = ck; wr_right_i = right; wr_vref_i = vref;
    @(negedge clk);
    wr_i = 0; wr_go_i = 0;
  endtask

  task automatic pulse_instr();
    instr_stb_i = 1; @(negedge clk); instr_stb_i = 0;
  endtask

  task automatic pulse_sleep();
    sleep_i = 1; @(negedge clk); sleep_i = 0;
  endtask

  task automatic pulse_rc();
    rc_tick_i = 1; @(negedge clk); rc_tick_i = 0;
  endtask

  function automatic logic [15:0] fmt(input logic [9:0] r, input logic right);
    return right ? {6'b0, r[9:8], r[7:0]} : {r[9:2], r[1:0], 6'b0};
  endfunction

  function automatic int div_of(input logic [2:0] ck);
    case (ck[1:0])
      2'b00: return 2;
      2'b01: return 8;
      default: return 32;
    endcase
  endfunction

  task automatic t_reset_state();
    chk("R1 adon", adon_o, 0);   chk("R1 busy", busy_o, 0);
    chk("R1 flag", flag_o, 0);   chk("R1 pwr", pwr_o, 0);
    chk("R1 wake", wake_o, 0);   chk("R1 chan_sel", chan_sel_o, 0);
    chk("R1 trial", trial_o, 0);
  endtask

  task automatic t_config();
    do_wr(1, 0, 3'd5, 3'b000, 0, 1);
    chk("R2 chan_sel one-hot", chan_sel_o, 8'h20);
    chk("R2 vref", vref_o, 1);
    chk("R2 pwr on", pwr_o, 1);
    chk("R2 busy idle", busy_o, 0);
    do_wr(0, 0, 3'd3, 3'b000, 0, 0);
    chk("R2 chan_sel off", chan_sel_o, 0);
    chk("R2 pwr off", pwr_o, 0);
  endtask

  task automatic t_go_disabled();
    do_wr(0, 1, 3'd1, 3'b000, 0, 0);
    chk("R3 start ignored when disabled", busy_o, 0);
    repeat (4) @(negedge clk);
    chk("R3 still idle", busy_o, 0);
  endtask

  task automatic t_conv(input logic [9:0] v, input logic [2:0] ck, input logic right);
    int d = div_of(ck);
    int k = 0;
    logic [15:0] e = fmt(v, right);
    vin = v;
    do_wr(1, 1, 3'd2, ck, right, 0);
    chk("R3 busy after start", busy_o, 1);
    while (busy_o && k < 2000) begin
      if (k == d) chk("R4 first trial", trial_o, 10'h200);
      k++;
      @(negedge clk);
    end
    chk("R7 conversion length", k, 11 * d);
    chk("R4 R6 result high", res_hi_o, e[15:8]);
    chk("R4 R6 result low", res_lo_o, e[7:0]);
    chk("R5 flag set", flag_o, 1);
  endtask

  task automatic t_flag();
    repeat (5) @(negedge clk);
    chk("R12 flag sticky", flag_o, 1);
    flag_clr_i = 1; @(negedge clk); flag_clr_i = 0;
    chk("R12 flag cleared", flag_o, 0);
  endtask

  task automatic t_busy_write();
    int k = 0;
    vin = 10'h1C3;
    do_wr(1, 1, 3'd2, 3'b010, 0, 0);
    while (busy_o && k < 2000) begin
      if (k == 40) begin
        wr_i = 1; wr_adon_i = 1; wr_go_i = 1; wr_chan_i = 3'd6; wr_clk_i = 3'b000;
      end
      if (k == 41) begin
        wr_i = 0; wr_go_i = 0;
        chk("R11 chan_sel held", chan_sel_o, 8'h04);
      end
      k++;
      @(negedge clk);
    end
    chk("R11 length unchanged", k, 352);
    chk("R11 result", {res_hi_o, res_lo_o[7:6]}, 10'h1C3);
    chk("R11 chan after", chan_sel_o, 8'h04);
  endtask

  task automatic t_abort();
    logic [7:0] hi, lo;
    flag_clr_i = 1; @(negedge clk); flag_clr_i = 0;
    hi = res_hi_o; lo = res_lo_o;
    vin = 10'h0F0;
    do_wr(1, 1, 3'd0, 3'b001, 0, 0);
    repeat (20) @(negedge clk);
    chk("R9 busy before sleep", busy_o, 1);
    pulse_sleep();
    chk("R9 aborted", busy_o, 0);
    chk("R9 power off", pwr_o, 0);
    chk("R9 adon kept", adon_o, 1);
    repeat (100) @(negedge clk);
    chk("R9 no flag", flag_o, 0);
    chk("R9 result high kept", res_hi_o, hi);
    chk("R9 result low kept", res_lo_o, lo);
    pulse_instr();
  endtask

  task automatic t_rc(input logic ie, input logic [9:0] v);
    int n = 0;
    ie_i = ie; vin = v;
    flag_clr_i = 1; @(negedge clk); flag_clr_i = 0;
    do_wr(1, 1, 3'd4, 3'b011, 1, 0);
    repeat (3) pulse_rc();
    chk("R8 held before instr", busy_o, 1);
    chk("R8 trial idle while held", trial_o, 0);
    pulse_instr();
    pulse_sleep();
    while (busy_o && n < 40) begin
      pulse_rc();
      n++;
    end
    chk("R8 tick count", n, 11);
    chk("R10 result through sleep", {res_hi_o[1:0], res_lo_o}, v);
    chk("R10 flag", flag_o, 1);
    chk("R10 adon kept", adon_o, 1);
    if (ie) begin
      chk("R10 wake pulse", wake_o, 1);
      chk("R10 power kept", pwr_o, 1);
      @(negedge clk);
      chk("R10 wake one cycle", wake_o, 0);
    end else begin
      chk("R10 no wake", wake_o, 0);
      chk("R10 powered down", pwr_o, 0);
    end
    pulse_instr();
    ie_i = 0;
  endtask

  task automatic t_reset_mid();
    logic [7:0] hi, lo;
    hi = res_hi_o; lo = res_lo_o;
    vin = 10'h2AA;
    do_wr(1, 1, 3'd7, 3'b010, 0, 0);
    repeat (50) @(negedge clk);
    rst_ni = 0;
    @(negedge clk);
    chk("R13 busy cleared", busy_o, 0);
    chk("R13 adon cleared", adon_o, 0);
    chk("R13 chan_sel cleared", chan_sel_o, 0);
    chk("R13 flag cleared", flag_o, 0);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    chk("R13 result high kept", res_hi_o, hi);
    chk("R13 result low kept", res_lo_o, lo);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset_state();
    t_config();
    t_go_disabled();
    t_conv(10'h2B5, 3'b000, 0);
    t_conv(10'h3FF, 3'b001, 1);
    t_conv(10'h000, 3'b100, 1);
    t_conv(10'h155, 3'b010, 0);
    t_flag();
    t_busy_write();
    t_abort();
    t_rc(1, 10'h27E);
    t_rc(0, 10'h001);
    t_reset_mid();
    fin = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule